// File: doc/BRIEF.md
# Serial programming port controller

This block is the target-side controller of a two-wire programming and verify port on a small microcontroller. An external programmer moves a serial clock and a data line. The controller shifts in 6-bit commands. It writes 14-bit words into an internal memory or returns them on the data line, and it keeps a 14-bit program counter that selects the word concerned. While programming is active, the rest of the chip is held in reset and its general I/O pins are forced to high-impedance inputs.

Programming becomes active through one of two paths:

- **High-voltage path:** a flag reports that the programming voltage is present.
- **Low-voltage path:** a dedicated pin rises while a configuration bit allows low-voltage entry.

The high-voltage flag always wins over the low-voltage path. When low-voltage entry is allowed, any edge on the low-voltage pin during programming clears the program counter.

All inputs pass through a synchronizer of parameterised depth and are sampled by the system clock. Memory is modelled as a small program array and a separate configuration/ID array.

Top module: `sprog_ctrl`

## Requirements
- R1: After reset, `core_hold` is 0 and `sdo_oe` is 0.
- R2: While `hv_flag` is 1, programming is active and `core_hold` is 1. Entering from the inactive state starts with the program counter at 0.
- R3: With `lvp_cfg_en` = 1, a rising edge on `lvp_pin` in the inactive state enters low-voltage programming (`core_hold` = 1). With `lvp_cfg_en` = 0, `lvp_pin` has no effect.
- R4: If `hv_flag` rises during low-voltage programming, the controller switches to high-voltage programming. The program counter and memory are kept.
- R5: A data transfer is 16 serial bits, LSB first. Bit 0 and bit 15 are zero pads and bits 14..1 carry the 14-bit word. A load whose pad bits are not both zero writes nothing.
- R6: A command is 6 bits, LSB first, with `sdi` sampled on each falling edge of `sclk`. The codes are:
  - 0x00: load configuration (sets the counter to 0x2000, then takes a data transfer to write there).
  - 0x02: load program word at the counter.
  - 0x04: read the word at the counter.
  - 0x06: increment the counter.
- R7: The program counter changes only by the increment command (+1), by load configuration (to 0x2000), or by being cleared to 0.
- R8: With `lvp_cfg_en` = 1 and programming active, any edge on `lvp_pin` clears the program counter to 0.
- R9: During a read, `sdo_oe` rises after the first rising `sclk` edge following the command. It stays 1 through the 16th falling edge and is 0 at all other times. `sdo` changes on rising `sclk` edges.
- R10: Command codes other than those in R6 are ignored and leave the counter unchanged. The controller then waits for the next command.
- R11: Addresses with bit 13 set select the configuration array, indexed by the low address bits. Other addresses select the program array. Every word reads 0x3FFF after reset.
- R12: Programming ends when `hv_flag` falls (high-voltage mode) or when `lvp_pin` falls (low-voltage mode). `core_hold` then returns to 0 and the counter is 0 on the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hv_flag | input | 1 | High programming voltage present |
| lvp_pin | input | 1 | Low-voltage programming request pin |
| lvp_cfg_en | input | 1 | Configuration bit allowing the low-voltage path |
| sclk | input | 1 | Serial programming clock |
| sdi | input | 1 | Serial data from the programmer |
| sdo | output | 1 | Serial data to the programmer |
| sdo_oe | output | 1 | Drive enable for the data line |
| core_hold | output | 1 | Holds the rest of the chip in reset and its I/O in high impedance |

## Verification
The hardest situation to reach is the overlap of the two entry paths: a counter preserved across a low-to-high-voltage handover, followed by a counter clear caused only by the low-voltage pin falling while the high-voltage flag keeps the mode alive. The stimulus gets there by entering low-voltage programming, writing a marker word at a non-zero address, and raising the high-voltage flag with the pin still high. A read then has to return the marker. After that the pin is dropped, and a second read must return the word at address 0 while `core_hold` never falls.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
   localparam int CMD_W = 6;
   localparam logic [CMD_W-1:0] CMD_LOAD_CFG  = 6'h00;
   localparam logic [CMD_W-1:0] CMD_LOAD_PROG = 6'h02;
   localparam logic [CMD_W-1:0] CMD_READ      = 6'h04;
   localparam logic [CMD_W-1:0] CMD_INC       = 6'h06;

   typedef enum logic [1:0] {MD_OFF, MD_HV, MD_LV} mode_e;
   typedef enum logic [1:0] {PH_CMD, PH_LOAD, PH_READ} phase_e;
endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("sprog_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] pipe [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pipe[s] <= '0;
            else if (s == 0) pipe[s] <= d;
            else             pipe[s] <= pipe[(s == 0) ? 0 : s-1];
         end
      end
      assign q = pipe[STAGES-1];
   end
endmodule

// File: rtl/sprog_mode.sv
module sprog_mode
   import sprog_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hv_s,
   input  logic pgm_s,
   input  logic lvp_en,
   output logic active,
   output logic pgm_clr
);
   mode_e st, st_nx;
   logic  pgm_q;

   always_comb begin
      st_nx = st;
      if (hv_s)                 st_nx = MD_HV;
      else if (st == MD_LV)     st_nx = (pgm_s && lvp_en) ? MD_LV : MD_OFF;
      else if (st == MD_OFF)    st_nx = (lvp_en && pgm_s && !pgm_q) ? MD_LV : MD_OFF;
      else                      st_nx = MD_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= MD_OFF;
         pgm_q <= 1'b0;
      end else begin
         st    <= st_nx;
         pgm_q <= pgm_s;
      end
   end

   assign active  = (st != MD_OFF);
   assign pgm_clr = lvp_en && active && (pgm_s != pgm_q);

   p_hv_takes_over_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hv_s |=> st == MD_HV);
   p_pgm_no_effect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == MD_OFF && !hv_s && !lvp_en) |=> st == MD_OFF);
   p_lv_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (st == MD_LV && !hv_s && !pgm_s) |=> st == MD_OFF);
endmodule

// File: rtl/sprog_mem.sv
module sprog_mem #(
   parameter int PC_W    = 14,
   parameter int WORD_W  = 14,
   parameter int PROG_AW = 6,
   parameter int CFG_AW  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PC_W-1:0]   wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [PC_W-1:0]   rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   localparam int PROG_D = 1 << PROG_AW;
   localparam int CFG_D  = 1 << CFG_AW;

   if (PROG_AW >= PC_W-1 || CFG_AW >= PC_W-1) begin : g_bad_aw
      $error("sprog_mem: array address wider than the counter region");
   end

   logic [WORD_W-1:0] prog [PROG_D];
   logic [WORD_W-1:0] cfg  [CFG_D];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PROG_D; i++) prog[i] <= '1;
         for (int i = 0; i < CFG_D; i++)  cfg[i]  <= '1;
      end else if (wr_en) begin
         if (wr_addr[PC_W-1]) cfg[wr_addr[CFG_AW-1:0]]   <= wr_data;
         else                 prog[wr_addr[PROG_AW-1:0]] <= wr_data;
      end
   end

   assign rd_data = rd_addr[PC_W-1] ? cfg[rd_addr[CFG_AW-1:0]]
                                    : prog[rd_addr[PROG_AW-1:0]];

   logic unused_addr_bits;
   assign unused_addr_bits = ^{wr_addr, rd_addr};
endmodule

// File: rtl/sprog_engine.sv
module sprog_engine
   import sprog_pkg::*;
#(
   parameter int PC_W   = 14,
   parameter int WORD_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              pgm_clr,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic [WORD_W-1:0] rd_word,
   output logic [PC_W-1:0]   pc,
   output logic              wr_en,
   output logic [PC_W-1:0]   wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic              sdo,
   output logic              sdo_oe
);
   localparam int XFER_W = WORD_W + 2;
   localparam int CNT_W  = $clog2(XFER_W);
   localparam logic [PC_W-1:0]  CFG_BASE = PC_W'(1) << (PC_W-1);
   localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W-1);
   localparam logic [CNT_W-1:0] XFR_LAST = CNT_W'(XFER_W-1);

   if (CMD_W > XFER_W) begin : g_bad_cmd
      $error("sprog_engine: command longer than a data transfer");
   end

   phase_e            phase;
   logic [CNT_W-1:0]  cnt;
   logic [XFER_W-1:0] shreg, outreg, frame_now;
   logic [CMD_W-1:0]  cmd_now;
   logic              sclk_q, sc_fall, sc_rise;

   assign sc_fall   = sclk_q && !sclk_s;
   assign sc_rise   = !sclk_q && sclk_s;
   assign frame_now = {sdi_s, shreg[XFER_W-1:1]};
   assign cmd_now   = {sdi_s, shreg[XFER_W-1 -: CMD_W-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_CMD;  cnt <= '0;  pc <= '0;
         shreg <= '0;  outreg <= '0;  sclk_q <= 1'b0;
         wr_en <= 1'b0;  wr_addr <= '0;  wr_data <= '0;
         sdo <= 1'b0;  sdo_oe <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         wr_en  <= 1'b0;
         if (!active) begin
            phase <= PH_CMD;  cnt <= '0;  pc <= '0;
            sdo <= 1'b0;  sdo_oe <= 1'b0;
         end else begin
            if (pgm_clr) pc <= '0;
            if (sc_fall) begin
               shreg <= frame_now;
               unique case (phase)
                  PH_CMD: begin
                     if (cnt == CMD_LAST) begin
                        cnt <= '0;
                        case (cmd_now)
                           CMD_LOAD_CFG: begin
                              if (!pgm_clr) pc <= CFG_BASE;
                              phase <= PH_LOAD;
                           end
                           CMD_LOAD_PROG: phase <= PH_LOAD;
                           CMD_READ: begin
                              outreg <= {1'b0, rd_word, 1'b0};
                              phase  <= PH_READ;
                           end
                           CMD_INC: if (!pgm_clr) pc <= pc + 1'b1;
                           default: ;
                        endcase
                     end else cnt <= cnt + 1'b1;
                  end
                  PH_LOAD: begin
                     if (cnt == XFR_LAST) begin
                        cnt   <= '0;
                        phase <= PH_CMD;
                        if (!frame_now[0] && !frame_now[XFER_W-1]) begin
                           wr_en   <= 1'b1;
                           wr_addr <= pc;
                           wr_data <= frame_now[XFER_W-2:1];
                        end
                     end else cnt <= cnt + 1'b1;
                  end
                  default: begin
                     if (cnt == XFR_LAST) begin
                        cnt    <= '0;
                        phase  <= PH_CMD;
                        sdo    <= 1'b0;
                        sdo_oe <= 1'b0;
                     end else cnt <= cnt + 1'b1;
                  end
               endcase
            end else if (sc_rise && phase == PH_READ) begin
               sdo_oe <= 1'b1;
               sdo    <= outreg[cnt];
            end
         end
      end
   end

   p_oe_only_reading_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> phase == PH_READ);
   p_pc_moves_legally_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc) |-> (pc == '0 || pc == CFG_BASE || pc == $past(pc) + 1'b1));
   p_idle_pc_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> pc == '0);
   p_pgm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_clr |=> pc == '0);
endmodule

// File: rtl/sprog_ctrl.sv
module sprog_ctrl #(
   parameter int PC_W        = 14,
   parameter int WORD_W      = 14,
   parameter int PROG_AW     = 6,
   parameter int CFG_AW      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hv_flag,
   input  logic lvp_pin,
   input  logic lvp_cfg_en,
   input  logic sclk,
   input  logic sdi,
   output logic sdo,
   output logic sdo_oe,
   output logic core_hold
);
   logic [4:0]        raw_in, syn_in;
   logic              active, pgm_clr, wr_en;
   logic [PC_W-1:0]   pc, wr_addr;
   logic [WORD_W-1:0] wr_data, rd_word;

   assign raw_in = {hv_flag, lvp_pin, lvp_cfg_en, sclk, sdi};

   sprog_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in));

   sprog_mode u_mode (
      .clk(clk), .rst_n(rst_n), .hv_s(syn_in[4]), .pgm_s(syn_in[3]),
      .lvp_en(syn_in[2]), .active(active), .pgm_clr(pgm_clr));

   sprog_engine #(.PC_W(PC_W), .WORD_W(WORD_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .active(active), .pgm_clr(pgm_clr),
      .sclk_s(syn_in[1]), .sdi_s(syn_in[0]), .rd_word(rd_word), .pc(pc),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sdo(sdo), .sdo_oe(sdo_oe));

   sprog_mem #(.PC_W(PC_W), .WORD_W(WORD_W), .PROG_AW(PROG_AW), .CFG_AW(CFG_AW)) u_mem (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(pc), .rd_data(rd_word));

   assign core_hold = active;

   p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !core_hold |-> !sdo_oe);
endmodule

// File: tb/sprog_ctrl_tb.sv
module sprog_ctrl_tb;
   localparam int HALF = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hv_flag = 0, lvp_pin = 0, lvp_cfg_en = 0, sclk = 0, sdi = 0;
   logic sdo, sdo_oe, core_hold;
   int   n_checks = 0, n_errors = 0;
   bit   finished = 0;

   always #2 clk = ~clk;

   sprog_ctrl u_dut (.clk(clk), .rst_n(rst_n), .hv_flag(hv_flag), .lvp_pin(lvp_pin),
      .lvp_cfg_en(lvp_cfg_en), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
      .core_hold(core_hold));

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); sdi = b; sclk = 1'b1;
      idle(HALF);
      sclk = 1'b0;
      idle(HALF);
   endtask

   task automatic send_cmd(input logic [5:0] c);
      for (int i = 0; i < 6; i++) send_bit(c[i]);
   endtask

   task automatic send_frame(input logic [15:0] f);
      for (int i = 0; i < 16; i++) send_bit(f[i]);
   endtask

   task automatic load_word(input logic [5:0] c, input logic [13:0] w);
      send_cmd(c);
      send_frame({1'b0, w, 1'b0});
   endtask

   // R9 window checked here, R5 pads checked on every read
   task automatic read_word(input string req, input logic [13:0] exp_w);
      logic [15:0] fr;
      int oe_bad;
      oe_bad = 0;
      send_cmd(6'h04);
      check("R9 oe low before first rise", int'(sdo_oe), 0);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk); sclk = 1'b1;
         idle(HALF);
         fr[i] = sdo;
         if (sdo_oe !== 1'b1) oe_bad++;
         sclk = 1'b0;
         idle(HALF);
      end
      check("R9 oe high over 16 bits", oe_bad, 0);
      idle(HALF);
      check("R9 oe released after read", int'(sdo_oe), 0);
      check("R5 pad bits zero", int'({fr[15], fr[0]}), 0);
      check(req, int'(fr[14:1]), int'(exp_w));
   endtask

   task automatic t_reset;
      check("R1 core_hold after reset", int'(core_hold), 0);
      check("R1 sdo_oe after reset", int'(sdo_oe), 0);
   endtask

   task automatic t_pgm_disabled;
      lvp_cfg_en = 0; lvp_pin = 1; idle(10);
      check("R3 pgm ignored when disabled", int'(core_hold), 0);
      lvp_pin = 0; idle(10);
   endtask

   task automatic t_high_voltage;
      hv_flag = 1; idle(10);
      check("R2 hold in hv mode", int'(core_hold), 1);
      read_word("R11 erased word at 0", 14'h3FFF);
      load_word(6'h02, 14'h1234);
      read_word("R6 load/read at 0", 14'h1234);
      send_cmd(6'h06);
      load_word(6'h02, 14'h0AAA);
      send_cmd(6'h3F);
      read_word("R10 unknown cmd keeps pc", 14'h0AAA);
      send_cmd(6'h02);
      send_frame(16'h8002);
      read_word("R5 bad pad load discarded", 14'h0AAA);
      load_word(6'h00, 14'h0155);
      read_word("R7 load cfg to 0x2000", 14'h0155);
      send_cmd(6'h06);
      read_word("R11 cfg word 1 erased", 14'h3FFF);
      hv_flag = 0; idle(10);
      check("R12 hold released", int'(core_hold), 0);
      hv_flag = 1; idle(10);
      read_word("R12 pc zero on reentry, R11 regions separate", 14'h1234);
      hv_flag = 0; idle(10);
   endtask

   task automatic t_low_voltage;
      lvp_cfg_en = 1; idle(5);
      lvp_pin = 1; idle(10);
      check("R3 lv entry", int'(core_hold), 1);
      repeat (3) send_cmd(6'h06);
      load_word(6'h02, 14'h2222);
      hv_flag = 1; idle(10);
      check("R4 hold kept on override", int'(core_hold), 1);
      read_word("R4 pc kept on hv override", 14'h2222);
      lvp_pin = 0; idle(10);
      check("R8 hv mode survives pgm fall", int'(core_hold), 1);
      read_word("R8 pgm edge cleared pc", 14'h1234);
      hv_flag = 0; idle(10);
      check("R12 exit after hv fall", int'(core_hold), 0);
      lvp_pin = 1; idle(10);
      check("R3 lv reentry", int'(core_hold), 1);
      lvp_pin = 0; idle(10);
      check("R12 lv exit on pgm fall", int'(core_hold), 0);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(4);
      t_reset();
      t_pgm_disabled();
      t_high_voltage();
      t_low_voltage();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule